// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block owns the program counter of a simple 32-bit in-order core and works out the address the fetch stage uses next. Each cycle it picks one of three candidates: the sequential address (current PC plus one 4-byte instruction), a conditional branch target, or an unconditional jump target. Both taken targets are measured from the sequential address, not from the current PC. A branch offset is 16 bits and a jump offset is 26 bits, and both are two's-complement values that are sign-extended to the full address width.

The decoder tells the block what the current instruction is: a branch (with a flag choosing test-for-zero or test-for-nonzero), a jump (with a flag asking for a link), or neither. A separate zero test on the first source operand comes in as one bit. For a jump with link, the block drives a register-file write strobe, the fixed destination index 31 and the return address in the same cycle. An advance enable freezes the PC for stalls. A synchronous reset loads address 0 and overrides the enable.

The block has no streaming data path. Every pin is a plain control or status signal that is sampled or driven every cycle, so there is no valid/ready handshake and no back-pressure.

Top module: `fetch_addr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0x00000000.
- R2: When `adv_en` is low and `rst` is low, `pc` keeps its value across the edge, whatever the branch and jump inputs are.
- R3: With `adv_en` high and neither `is_branch` nor `is_jump` asserted, `pc` advances by 4 at the edge.
- R4: Branch on zero (`is_branch`=1, `test_nonzero`=0) is taken when `src_is_zero`=1, giving `pc + 4 + sext(br_off)`. Otherwise the PC advances by 4.
- R5: Branch on nonzero (`is_branch`=1, `test_nonzero`=1) is taken when `src_is_zero`=0, giving `pc + 4 + sext(br_off)`. Otherwise the PC advances by 4.
- R6: With `is_jump`=1 the new PC is `pc + 4 + sext(jmp_off)`, where bit 25 of `jmp_off` is the sign bit.
- R7: `link_we` is 1 exactly when `adv_en`, `is_jump` and `jump_link` are all 1. While it is 1, `link_addr` is 31 and `link_data` is `pc + 4` in that same cycle. A jump without link writes nothing.
- R8: When `is_jump` and a taken branch are both asserted, the jump target wins.
- R9: `next_pc` always shows the value `pc` takes at the next edge when `rst` is low. When `adv_en` is low, that value is `pc` itself. All address arithmetic wraps modulo 2^32.
- R10: Reset takes priority over `adv_en` and over any redirect that is requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; low holds the PC |
| is_branch | input | 1 | Current instruction is a conditional branch |
| test_nonzero | input | 1 | Branch condition: 0 = taken on zero, 1 = taken on nonzero |
| src_is_zero | input | 1 | First source operand equals zero |
| is_jump | input | 1 | Current instruction is an unconditional jump |
| jump_link | input | 1 | The jump also saves a return address |
| br_off | input | 16 | Signed branch offset |
| jmp_off | input | 26 | Signed jump offset |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next edge |
| link_we | output | 1 | Register-file write strobe for the return address |
| link_addr | output | 5 | Destination register index of the link write |
| link_data | output | 32 | Return address (pc + 4) |

## Verification
The hardest case to reach from the ports is address wrap-around. The PC starts at zero and only moves in steps of 4 or by bounded offsets, so neither end of the address space is reachable directly. The stimulus resets to 0, then issues a jump with a negative 26-bit offset, which carries the PC below zero to 0xFFFFFF04. A sequential step follows, and then a positive jump that carries the PC past 0xFFFFFFFF back to a small address. Together these steps check the modulo arithmetic in both directions and confirm that sign extension uses bit 25.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2
  } redirect_e;
endpackage

// File: rtl/fas_sext.sv
module fas_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_trunc
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fas_target_calc.sv
module fas_target_calc #(
  parameter int ADDR_W      = 32,
  parameter int BOFF_W      = 16,
  parameter int JOFF_W      = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [BOFF_W-1:0] br_off,
  input  logic [JOFF_W-1:0] jmp_off,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr,
  output logic [ADDR_W-1:0] jmp_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] br_ext;
  logic [ADDR_W-1:0] jmp_ext;

  fas_sext #(.IN_W(BOFF_W), .OUT_W(ADDR_W)) u_br_ext (
    .din  (br_off),
    .dout (br_ext)
  );

  fas_sext #(.IN_W(JOFF_W), .OUT_W(ADDR_W)) u_jmp_ext (
    .din  (jmp_off),
    .dout (jmp_ext)
  );

  // Both redirect targets are relative to the sequential address.
  assign seq_addr = cur_pc + STEP;
  assign br_addr  = seq_addr + br_ext;
  assign jmp_addr = seq_addr + jmp_ext;
endmodule

// File: rtl/fas_redirect.sv
module fas_redirect
  import fas_pkg::*;
(
  input  logic      is_branch,
  input  logic      test_nonzero,
  input  logic      src_is_zero,
  input  logic      is_jump,
  output redirect_e sel
);
  logic br_taken;

  assign br_taken = is_branch && (src_is_zero != test_nonzero);

  // Jump wins over a branch flagged in the same cycle.
  always_comb begin
    if (is_jump)       sel = SEL_JUMP;
    else if (br_taken) sel = SEL_BRANCH;
    else               sel = SEL_SEQ;
  end
endmodule

// File: rtl/fas_pc_reg.sv
module fas_pc_reg #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RESET_PC;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fetch_addr_seq.sv
module fetch_addr_seq
  import fas_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BOFF_W      = 16,
  parameter int JOFF_W      = 26,
  parameter int INSTR_BYTES = 4,
  parameter int REG_IDX_W   = 5,
  parameter int LINK_REG    = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_en,
  input  logic                 is_branch,
  input  logic                 test_nonzero,
  input  logic                 src_is_zero,
  input  logic                 is_jump,
  input  logic                 jump_link,
  input  logic [BOFF_W-1:0]    br_off,
  input  logic [JOFF_W-1:0]    jmp_off,
  output logic [ADDR_W-1:0]    pc,
  output logic [ADDR_W-1:0]    next_pc,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_addr,
  output logic [ADDR_W-1:0]    link_data
);
  localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

  logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, chosen;
  redirect_e         sel;

  fas_target_calc #(
    .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_tgt (
    .cur_pc   (pc),
    .br_off   (br_off),
    .jmp_off  (jmp_off),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  fas_redirect u_sel (
    .is_branch    (is_branch),
    .test_nonzero (test_nonzero),
    .src_is_zero  (src_is_zero),
    .is_jump      (is_jump),
    .sel          (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_JUMP:   chosen = jmp_addr;
      SEL_BRANCH: chosen = br_addr;
      default:    chosen = seq_addr;
    endcase
  end

  assign next_pc = adv_en ? chosen : pc;

  fas_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC('0)) u_pc (
    .clk (clk),
    .rst (rst),
    .en  (adv_en),
    .d   (chosen),
    .q   (pc)
  );

  // The return address is the sequential address, written in the jump's own cycle.
  assign link_we   = adv_en && is_jump && jump_link;
  assign link_addr = LINK_IDX;
  assign link_data = seq_addr;
endmodule

// File: rtl/fas_checker.sv
module fas_checker #(
  parameter int ADDR_W      = 32,
  parameter int BOFF_W      = 16,
  parameter int JOFF_W      = 26,
  parameter int INSTR_BYTES = 4,
  parameter int REG_IDX_W   = 5,
  parameter int LINK_REG    = 31
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 adv_en,
  input logic                 is_branch,
  input logic                 test_nonzero,
  input logic                 src_is_zero,
  input logic                 is_jump,
  input logic                 jump_link,
  input logic [BOFF_W-1:0]    br_off,
  input logic [JOFF_W-1:0]    jmp_off,
  input logic [ADDR_W-1:0]    pc,
  input logic [ADDR_W-1:0]    next_pc,
  input logic                 link_we,
  input logic [REG_IDX_W-1:0] link_addr,
  input logic [ADDR_W-1:0]    link_data
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] bx, jx;
  assign bx = {{(ADDR_W-BOFF_W){br_off[BOFF_W-1]}}, br_off};
  assign jx = {{(ADDR_W-JOFF_W){jmp_off[JOFF_W-1]}}, jmp_off};

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> pc == $past(pc));

  p_seq_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !is_jump && !is_branch) |=> pc == $past(pc) + STEP);

  p_bz_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !is_jump && is_branch && !test_nonzero && src_is_zero)
      |=> pc == $past(pc) + STEP + $past(bx));

  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (adv_en && is_jump) |=> pc == $past(pc) + STEP + $past(jx));

  p_link_r7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_addr == REG_IDX_W'(LINK_REG)) && (link_data == pc + STEP));

  p_nolink_r7: assert property (@(posedge clk) disable iff (rst)
    (!adv_en || !is_jump || !jump_link) |-> !link_we);

  p_next_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(next_pc));
endmodule

bind fetch_addr_seq fas_checker #(
  .ADDR_W(ADDR_W), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W),
  .INSTR_BYTES(INSTR_BYTES), .REG_IDX_W(REG_IDX_W), .LINK_REG(LINK_REG)
) u_chk (
  .clk(clk), .rst(rst), .adv_en(adv_en), .is_branch(is_branch),
  .test_nonzero(test_nonzero), .src_is_zero(src_is_zero), .is_jump(is_jump),
  .jump_link(jump_link), .br_off(br_off), .jmp_off(jmp_off), .pc(pc),
  .next_pc(next_pc), .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
);

// File: tb/sim_fetch_addr_seq.sv
`timescale 1ns/1ps
module sim_fetch_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0, is_branch = 1'b0, test_nonzero = 1'b0;
  logic        src_is_zero = 1'b0, is_jump = 1'b0, jump_link = 1'b0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_off = '0;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_addr;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] model_pc = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_addr_seq u0 (
    .clk(clk), .rst(rst), .adv_en(adv_en), .is_branch(is_branch),
    .test_nonzero(test_nonzero), .src_is_zero(src_is_zero), .is_jump(is_jump),
    .jump_link(jump_link), .br_off(br_off), .jmp_off(jmp_off), .pc(pc),
    .next_pc(next_pc), .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic br, input logic nz, input logic zr,
                       input logic jp, input logic lk, input logic [15:0] bo,
                       input logic [25:0] jo);
    adv_en = en; is_branch = br; test_nonzero = nz; src_is_zero = zr;
    is_jump = jp; jump_link = lk; br_off = bo; jmp_off = jo;
  endtask

  function automatic logic [31:0] bt(input logic [31:0] p, input logic [15:0] o);
    return p + 32'd4 + {{16{o[15]}}, o};
  endfunction

  function automatic logic [31:0] jt(input logic [31:0] p, input logic [25:0] o);
    return p + 32'd4 + {{6{o[25]}}, o};
  endfunction

  // Inputs already driven; check the lookahead, clock once, check the PC.
  task automatic step(input string req, input logic [31:0] exp);
    #1;
    check({req, " next_pc"}, next_pc, exp);
    @(posedge clk); #1;
    check({req, " pc"}, pc, exp);
    model_pc = exp;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(1, 0, 0, 0, 1, 1, 16'h0, 26'h0000100);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset pc", pc, 32'h0);
    check("R10 reset beats jump", pc, 32'h0);
    rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 16'h0, 26'h0);
    model_pc = 32'h0;
  endtask

  task automatic t_seq();
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, 0, 0, 0, 16'h0, 26'h0);
      step("R3 sequential", model_pc + 32'd4);
    end
  endtask

  task automatic t_bz();
    drive(1, 1, 0, 1, 0, 0, 16'h0010, 26'h0);
    step("R4 beqz taken fwd", bt(model_pc, 16'h0010));
    drive(1, 1, 0, 1, 0, 0, 16'hFFF8, 26'h0);
    step("R4 beqz taken back", bt(model_pc, 16'hFFF8));
    drive(1, 1, 0, 0, 0, 0, 16'h0100, 26'h0);
    step("R4 beqz not taken", model_pc + 32'd4);
  endtask

  task automatic t_bnz();
    drive(1, 1, 1, 0, 0, 0, 16'h0040, 26'h0);
    step("R5 bnez taken", bt(model_pc, 16'h0040));
    drive(1, 1, 1, 1, 0, 0, 16'h0040, 26'h0);
    step("R5 bnez not taken", model_pc + 32'd4);
  endtask

  task automatic t_jump();
    drive(1, 0, 0, 0, 1, 0, 16'h0, 26'h0100000);
    #1;
    check("R7 plain jump no link", {31'd0, link_we}, 32'd0);
    step("R6 jump fwd", jt(model_pc, 26'h0100000));
    drive(1, 0, 0, 0, 1, 0, 16'h0, 26'h3FFFFFC);
    step("R6 jump self", model_pc);
  endtask

  task automatic t_jal();
    logic [31:0] ret;
    ret = model_pc + 32'd4;
    drive(1, 0, 0, 0, 1, 1, 16'h0, 26'h0000200);
    #1;
    check("R7 link_we", {31'd0, link_we}, 32'd1);
    check("R7 link_addr", {27'd0, link_addr}, 32'd31);
    check("R7 link_data", link_data, ret);
    step("R6 jal target", jt(model_pc, 26'h0000200));
  endtask

  task automatic t_hold();
    drive(0, 0, 0, 0, 1, 1, 16'h0, 26'h0001000);
    #1;
    check("R7 no link when stalled", {31'd0, link_we}, 32'd0);
    step("R2 hold jump", model_pc);
    drive(0, 1, 0, 1, 0, 0, 16'h0020, 26'h0);
    step("R2 hold branch", model_pc);
  endtask

  task automatic t_prio();
    drive(1, 1, 0, 1, 1, 0, 16'h0800, 26'h0000040);
    step("R8 jump over branch", jt(model_pc, 26'h0000040));
  endtask

  task automatic t_wrap();
    do_reset();
    drive(1, 0, 0, 0, 1, 0, 16'h0, 26'h3FFFF00);
    step("R9 wrap below zero", 32'hFFFFFF04);
    drive(1, 0, 0, 0, 0, 0, 16'h0, 26'h0);
    step("R9 seq near top", 32'hFFFFFF08);
    drive(1, 0, 0, 0, 1, 0, 16'h0, 26'h00000F8);
    step("R9 wrap past top", 32'h00000004);
  endtask

  initial begin
    @(posedge clk); #1;
    do_reset();
    t_seq();
    t_bz();
    t_bnz();
    t_jump();
    t_jal();
    t_hold();
    t_prio();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule